// File: doc/BRIEF.md
# Low-Power Mode Control Sequencer

This sequencer chooses the operating condition of a microcontroller. It can be running, in sleep, in software standby, in hardware standby, or held in reset. A single decode of that condition drives the CPU clock gate, the peripheral clock gate, the refresh-logic resets, the clock-output pin mode and the I/O port high-impedance control. A per-module standby register sits beside this mode logic. Each bit set in it halts one peripheral, holds that peripheral's registers in reset and floats its outputs. Clearing the bit lets the peripheral run again, and software must then set it up once more.

The CPU gives a one-cycle sleep strobe. The software-standby select bit picks which mode that strobe enters. Sleep keeps the peripherals and refresh running and wakes on any interrupt. Software standby stops everything and resets the peripherals. It wakes only on the non-maskable interrupt or one of the three external interrupt lines, and it then waits a programmable oscillator-settling count before the CPU clock returns. A low level on the active-low standby pin forces hardware standby at once, with no clock needed. The sequencer leaves hardware standby only when that pin returns high while the reset input is low, and it stays in reset until reset is released. On-chip RAM is not touched by any of these modes. Software must turn RAM access off before it lets the standby pin fall.

Top module: `lpm_sequencer`

## Requirements
- R1: In sleep, cpuClkEn is 0, periphClkEn is 1, every modEn bit whose standby bit is 0 is 1, clkPinMode is 00 (drive clock) and rfshCntRst is 0. Sleep is entered on the edge that samples sleepStb=1 with swStbySel=0 while running.
- R2: From sleep, intReq, nmi or any extIrq bit sampled high returns the sequencer to running on that same edge, so cpuClkEn is 1 after it.
- R3: sleepStb=1 with swStbySel=1 while running enters software standby. In that state cpuClkEn and periphClkEn are 0, every modRst bit is 1, clkPinMode is 01 (held high), rfshCntRst is 1 and rfshFullRst is 0.
- R4: In software standby, intReq has no effect. The outputs keep their standby values.
- R5: nmi or any extIrq bit wakes software standby into a settling phase. That phase lasts settleCount+1 cycles with the software-standby outputs, and after it the sequencer runs (cpuClkEn=1).
- R6: When stbyN goes low, hardware standby begins at once from any state, without a clock edge. In hardware standby clkPinMode is 10 (high impedance), portHiZ is 1, and every modHiZ and modRst bit is 1. rfshFullRst is 1 and cpuClkEn is 0.
- R7: With stbyN high, hardware standby stays in force while rstN is high. It moves to the reset state only on an edge that samples rstN low.
- R8: rstN sampled low in any state other than hardware standby moves the sequencer to reset. In reset, cpuClkEn and periphClkEn are 0, every modRst bit is 1, rfshFullRst is 1, clkPinMode is 00 and portHiZ is 0. The first edge that samples rstN high moves it to running.
- R9: A modStbyWr pulse while running loads modStbyData into the module-standby register. For each bit set to 1, modEn is 0, modRst is 1 and modHiZ is 1. Writing 0 restores modEn to 1 and drops modRst and modHiZ.
- R10: modStbyWr while the CPU clock is stopped (sleep, standby, settling, reset) has no effect on the module-standby register.
- R11: The module-standby register is cleared by reset and by hardware standby, so every module leaves module standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Reset input, active low, sampled on the clock |
| stbyN | input | 1 | Standby pin, active low, forces hardware standby asynchronously |
| sleepStb | input | 1 | One-cycle pulse from the executed sleep instruction |
| swStbySel | input | 1 | 1 makes the sleep strobe enter software standby instead of sleep |
| nmi | input | 1 | Non-maskable interrupt request |
| extIrq | input | NEXT | External interrupt lines 0 to 2 |
| intReq | input | 1 | Any enabled interrupt request (sleep wake only) |
| settleCount | input | CW | Oscillator-settling cycles minus one after a standby wake |
| modStbyWr | input | 1 | Write strobe for the module-standby register |
| modStbyData | input | NMOD | Value written to the module-standby register |
| cpuClkEn | output | 1 | CPU clock enable |
| periphClkEn | output | 1 | Peripheral, DMA and refresh clock enable |
| modEn | output | NMOD | Per-module run enable |
| modRst | output | NMOD | Per-module register reset |
| modHiZ | output | NMOD | Per-module output high-impedance control |
| rfshCntRst | output | 1 | Resets the refresh counter and the top two control bits |
| rfshFullRst | output | 1 | Resets the whole refresh controller |
| clkPinMode | output | 2 | Clock-output pin: 00 drive, 01 high, 10 high impedance |
| portHiZ | output | 1 | All I/O ports to high impedance |

## Verification
The settling phase is the hardest part to observe from the ports. Its outputs match software standby exactly, so the only visible sign is when cpuClkEn comes back. The stimulus wakes software standby once through an external line and once through nmi, with a settle count of 2. Each wake is followed by idle vectors, and the cycle in which cpuClkEn rises is checked against settleCount+1. To check that hardware standby is asynchronous, the standby pin is dropped in the middle of a clock period and the port and pin controls are sampled 1 ns later, before any edge.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [2:0] {
    ST_RESET  = 3'd0,
    ST_RUN    = 3'd1,
    ST_SLEEP  = 3'd2,
    ST_SWSTBY = 3'd3,
    ST_SETTLE = 3'd4,
    ST_HWSTBY = 3'd5
  } lpm_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic run;
    logic sleep;
    logic swStby;
    logic settle;
    logic hwStby;
    logic reset;
    logic cntLoad;
    logic modWrEn;
    logic modClr;
  } lpm_ctl_t;

  localparam logic [1:0] PIN_DRIVE = 2'b00;
  localparam logic [1:0] PIN_HIGH  = 2'b01;
  localparam logic [1:0] PIN_HIZ   = 2'b10;

endpackage

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int NEXT = 3
) (
  input  logic            clk,
  input  logic            stbyN,
  input  logic            rstN,
  input  logic            sleepStb,
  input  logic            swStbySel,
  input  logic            nmi,
  input  logic [NEXT-1:0] extIrq,
  input  logic            intReq,
  input  logic            cntZero,
  output lpm_ctl_t        ctl
);

  lpm_state_e state, nextState;
  logic stbyWake, sleepWake;

  assign stbyWake  = nmi | (|extIrq);
  assign sleepWake = stbyWake | intReq;

  always_comb begin
    nextState = state;
    if (state == ST_HWSTBY) begin
      if (!rstN) nextState = ST_RESET;
    end else if (!rstN) begin
      nextState = ST_RESET;
    end else begin
      unique case (state)
        ST_RESET:  nextState = ST_RUN;
        ST_RUN:    if (sleepStb) nextState = swStbySel ? ST_SWSTBY : ST_SLEEP;
        ST_SLEEP:  if (sleepWake) nextState = ST_RUN;
        ST_SWSTBY: if (stbyWake) nextState = ST_SETTLE;
        ST_SETTLE: if (cntZero) nextState = ST_RUN;
        default:   nextState = ST_RESET;
      endcase
    end
  end

  always_ff @(posedge clk or negedge stbyN) begin
    if (!stbyN) state <= ST_HWSTBY;
    else        state <= nextState;
  end

  always_comb begin
    ctl         = '0;
    ctl.run     = (state == ST_RUN);
    ctl.sleep   = (state == ST_SLEEP);
    ctl.swStby  = (state == ST_SWSTBY);
    ctl.settle  = (state == ST_SETTLE);
    ctl.hwStby  = (state == ST_HWSTBY);
    ctl.reset   = (state == ST_RESET);
    ctl.cntLoad = (state == ST_SWSTBY) && rstN && stbyWake;
    ctl.modWrEn = (state == ST_RUN) && rstN;
    ctl.modClr  = !rstN;
  end

endmodule

// File: rtl/lpm_dpath.sv
module lpm_dpath
  import lpm_pkg::*;
#(
  parameter int NMOD = 6,
  parameter int CW   = 8
) (
  input  logic            clk,
  input  logic            stbyN,
  input  lpm_ctl_t        ctl,
  input  logic [CW-1:0]   settleCount,
  input  logic            modStbyWr,
  input  logic [NMOD-1:0] modStbyData,
  output logic            cntZero,
  output logic            cpuClkEn,
  output logic            periphClkEn,
  output logic [NMOD-1:0] modEn,
  output logic [NMOD-1:0] modRst,
  output logic [NMOD-1:0] modHiZ,
  output logic            rfshCntRst,
  output logic            rfshFullRst,
  output logic [1:0]      clkPinMode,
  output logic            portHiZ
);

  logic [CW-1:0]   settleCnt;
  logic [NMOD-1:0] modStbyReg;
  logic            active, allRst;

  // oscillator settling counter
  always_ff @(posedge clk or negedge stbyN) begin
    if (!stbyN)                         settleCnt <= '0;
    else if (ctl.cntLoad)               settleCnt <= settleCount;
    else if (ctl.settle && !cntZero)    settleCnt <= settleCnt - 1'b1;
  end
  assign cntZero = (settleCnt == '0);

  // module standby register
  always_ff @(posedge clk or negedge stbyN) begin
    if (!stbyN)                          modStbyReg <= '0;
    else if (ctl.modClr)                 modStbyReg <= '0;
    else if (modStbyWr && ctl.modWrEn)   modStbyReg <= modStbyData;
  end

  assign active      = ctl.run | ctl.sleep;
  assign allRst      = ctl.reset | ctl.swStby | ctl.settle | ctl.hwStby;
  assign cpuClkEn    = ctl.run;
  assign periphClkEn = active;
  assign rfshCntRst  = allRst;
  assign rfshFullRst = ctl.reset | ctl.hwStby;
  assign portHiZ     = ctl.hwStby;

  always_comb begin
    if (ctl.hwStby)                     clkPinMode = PIN_HIZ;
    else if (ctl.swStby || ctl.settle)  clkPinMode = PIN_HIGH;
    else                                clkPinMode = PIN_DRIVE;
  end

  for (genvar i = 0; i < NMOD; i++) begin : g_mod
    assign modEn[i]  = active & ~modStbyReg[i];
    assign modRst[i] = allRst | modStbyReg[i];
    assign modHiZ[i] = ctl.hwStby | modStbyReg[i];
  end

endmodule

// File: rtl/lpm_sequencer.sv
module lpm_sequencer
  import lpm_pkg::*;
#(
  parameter int NMOD = 6,
  parameter int NEXT = 3,
  parameter int CW   = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            stbyN,
  input  logic            sleepStb,
  input  logic            swStbySel,
  input  logic            nmi,
  input  logic [NEXT-1:0] extIrq,
  input  logic            intReq,
  input  logic [CW-1:0]   settleCount,
  input  logic            modStbyWr,
  input  logic [NMOD-1:0] modStbyData,
  output logic            cpuClkEn,
  output logic            periphClkEn,
  output logic [NMOD-1:0] modEn,
  output logic [NMOD-1:0] modRst,
  output logic [NMOD-1:0] modHiZ,
  output logic            rfshCntRst,
  output logic            rfshFullRst,
  output logic [1:0]      clkPinMode,
  output logic            portHiZ
);

  lpm_ctl_t ctl;
  logic     cntZero;

  lpm_ctrl #(.NEXT(NEXT)) u_ctrl (
    .clk(clk), .stbyN(stbyN), .rstN(rstN), .sleepStb(sleepStb),
    .swStbySel(swStbySel), .nmi(nmi), .extIrq(extIrq), .intReq(intReq),
    .cntZero(cntZero), .ctl(ctl)
  );

  lpm_dpath #(.NMOD(NMOD), .CW(CW)) u_dpath (
    .clk(clk), .stbyN(stbyN), .ctl(ctl), .settleCount(settleCount),
    .modStbyWr(modStbyWr), .modStbyData(modStbyData), .cntZero(cntZero),
    .cpuClkEn(cpuClkEn), .periphClkEn(periphClkEn), .modEn(modEn),
    .modRst(modRst), .modHiZ(modHiZ), .rfshCntRst(rfshCntRst),
    .rfshFullRst(rfshFullRst), .clkPinMode(clkPinMode), .portHiZ(portHiZ)
  );

endmodule

// File: rtl/lpm_sequencer_chk.sv
module lpm_sequencer_chk #(
  parameter int NMOD = 6,
  parameter int NEXT = 3
) (
  input logic            clk,
  input logic            rstN,
  input logic            stbyN,
  input logic            nmi,
  input logic [NEXT-1:0] extIrq,
  input logic            intReq,
  input logic            cpuClkEn,
  input logic            periphClkEn,
  input logic [NMOD-1:0] modEn,
  input logic [NMOD-1:0] modRst,
  input logic [NMOD-1:0] modHiZ,
  input logic            rfshCntRst,
  input logic            rfshFullRst,
  input logic [1:0]      clkPinMode,
  input logic            portHiZ
);

  // R1
  sleep_refresh_chk: assert property (@(posedge clk) disable iff (!stbyN)
    periphClkEn |-> !rfshCntRst && !rfshFullRst && clkPinMode == 2'b00);

  // R2
  sleep_wake_chk: assert property (@(posedge clk) disable iff (!stbyN)
    (!cpuClkEn && periphClkEn && rstN && (intReq || nmi || (|extIrq))) |=> cpuClkEn);

  // R3
  sw_outputs_chk: assert property (@(posedge clk) disable iff (!stbyN)
    (clkPinMode == 2'b01) |-> !periphClkEn && !cpuClkEn && rfshCntRst && !rfshFullRst && (&modRst));

  // R6
  hw_hiz_chk: assert property (@(posedge clk) disable iff (!stbyN)
    portHiZ |-> clkPinMode == 2'b10 && (&modHiZ) && (&modRst) && rfshFullRst && !cpuClkEn);

  // R7
  hw_stay_chk: assert property (@(posedge clk) disable iff (!stbyN)
    (portHiZ && rstN) |=> portHiZ);

  // R8
  rst_entry_chk: assert property (@(posedge clk) disable iff (!stbyN)
    (!rstN && !portHiZ) |=> !cpuClkEn && rfshFullRst && !portHiZ);

  // R9
  mod_excl_chk: assert property (@(posedge clk) disable iff (!stbyN)
    (modEn & modRst) == '0);

  // R10
  mod_hold_chk: assert property (@(posedge clk) disable iff (!stbyN)
    (!$past(cpuClkEn) && !$past(portHiZ) && !portHiZ && $past(rstN)) |-> $stable(modHiZ));

endmodule

bind lpm_sequencer lpm_sequencer_chk #(.NMOD(NMOD), .NEXT(NEXT)) u_chk (.*);

// File: tb/lpm_sequencer_bench.sv
module lpm_sequencer_bench;

  localparam int NMOD = 6;
  localparam int NEXT = 3;
  localparam int CW   = 8;
  localparam logic [NMOD-1:0] ONES = '1;

  logic clk = 1'b0;
  logic rstN = 1'b0, stbyN = 1'b0;
  logic sleepStb = 1'b0, swStbySel = 1'b0, nmi = 1'b0, intReq = 1'b0;
  logic [NEXT-1:0] extIrq = '0;
  logic [CW-1:0]   settleCount = 8'd2;
  logic            modStbyWr = 1'b0;
  logic [NMOD-1:0] modStbyData = '0;
  logic cpuClkEn, periphClkEn, rfshCntRst, rfshFullRst, portHiZ;
  logic [NMOD-1:0] modEn, modRst, modHiZ;
  logic [1:0] clkPinMode;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  lpm_sequencer #(.NMOD(NMOD), .NEXT(NEXT), .CW(CW)) u_lpm_sequencer (
    .clk(clk), .rstN(rstN), .stbyN(stbyN), .sleepStb(sleepStb),
    .swStbySel(swStbySel), .nmi(nmi), .extIrq(extIrq), .intReq(intReq),
    .settleCount(settleCount), .modStbyWr(modStbyWr), .modStbyData(modStbyData),
    .cpuClkEn(cpuClkEn), .periphClkEn(periphClkEn), .modEn(modEn),
    .modRst(modRst), .modHiZ(modHiZ), .rfshCntRst(rfshCntRst),
    .rfshFullRst(rfshFullRst), .clkPinMode(clkPinMode), .portHiZ(portHiZ)
  );

  // [11]sleep [10]swSel [9]nmi [8:6]ext [5]intReq | [4]cpu [3]periph [2:1]pin [0]all modEn
  localparam logic [11:0] VEC [0:16] = '{
    12'b0000000_11001, // R1 idle run
    12'b1000000_01001, // R1 enter sleep
    12'b0000000_01001, // R1 stay asleep
    12'b0000001_11001, // R2 wake by intReq
    12'b1100000_00010, // R3 enter software standby
    12'b0000001_00010, // R4 intReq ignored
    12'b0000100_00010, // R5 ext1 wake, settling
    12'b0000000_00010, // R5
    12'b0000000_00010, // R5
    12'b0000000_11001, // R5 running after 3 cycles
    12'b1000000_01001, // R1
    12'b0000010_11001, // R2 wake by ext0
    12'b1100000_00010, // R3
    12'b0010000_00010, // R5 nmi wake
    12'b0000000_00010, // R5
    12'b0000000_00010, // R5
    12'b0000000_11001  // R5
  };

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R6 power-on in hardware standby
    chk("R6 pin", 32'(clkPinMode), 32'(2'b10));
    chk("R6 ports", 32'(portHiZ), 32'd1);
    chk("R6 modHiZ", 32'(modHiZ), 32'(ONES));
    chk("R6 full refresh reset", 32'(rfshFullRst), 32'd1);
    // R7 pin high with reset released: stays
    rstN = 1'b1; stbyN = 1'b1;
    step();
    chk("R7 stay hw", 32'(portHiZ), 32'd1);
    rstN = 1'b0;
    step();
    // R8 reset state
    chk("R8 reset ports", 32'(portHiZ), 32'd0);
    chk("R8 reset pin", 32'(clkPinMode), 32'(2'b00));
    chk("R8 reset cpu", 32'(cpuClkEn), 32'd0);
    chk("R8 reset modRst", 32'(modRst), 32'(ONES));
    chk("R8 reset refresh", 32'(rfshFullRst), 32'd1);
    rstN = 1'b1;
    step();
    chk("R8 run after reset", 32'(cpuClkEn), 32'd1);

    // vector table
    for (int i = 0; i < 17; i++) begin
      {sleepStb, swStbySel, nmi, extIrq, intReq} = VEC[i][11:5];
      step();
      {sleepStb, swStbySel, nmi, extIrq, intReq} = '0;
      chk($sformatf("R1-5 vec%0d cpu", i), 32'(cpuClkEn), 32'(VEC[i][4]));
      chk($sformatf("R1-5 vec%0d periph", i), 32'(periphClkEn), 32'(VEC[i][3]));
      chk($sformatf("R1-5 vec%0d pin", i), 32'(clkPinMode), 32'(VEC[i][2:1]));
      chk($sformatf("R1-5 vec%0d modEn", i), 32'(modEn), VEC[i][0] ? 32'(ONES) : 32'd0);
    end

    // R9 module standby
    modStbyWr = 1'b1; modStbyData = 6'b000101;
    step();
    modStbyWr = 1'b0;
    chk("R9 modEn", 32'(modEn), 32'(6'b111010));
    chk("R9 modRst", 32'(modRst), 32'(6'b000101));
    chk("R9 modHiZ", 32'(modHiZ), 32'(6'b000101));
    // R10 write while asleep ignored
    sleepStb = 1'b1; step(); sleepStb = 1'b0;
    chk("R1 sleep refresh runs", 32'(rfshCntRst), 32'd0);
    modStbyWr = 1'b1; modStbyData = 6'b111111; step(); modStbyWr = 1'b0;
    nmi = 1'b1; step(); nmi = 1'b0;
    chk("R2 nmi wake", 32'(cpuClkEn), 32'd1);
    chk("R10 write ignored", 32'(modHiZ), 32'(6'b000101));
    modStbyWr = 1'b1; modStbyData = '0; step(); modStbyWr = 1'b0;
    chk("R9 restart", 32'(modEn), 32'(ONES));
    // R11 reset clears module standby
    modStbyWr = 1'b1; modStbyData = 6'b000011; step(); modStbyWr = 1'b0;
    chk("R9 set", 32'(modHiZ), 32'(6'b000011));
    rstN = 1'b0; step(); rstN = 1'b1; step();
    chk("R11 modEn", 32'(modEn), 32'(ONES));
    chk("R11 modRst", 32'(modRst), 32'd0);

    // R3 standby detail, then R8 reset from standby
    sleepStb = 1'b1; swStbySel = 1'b1; step(); sleepStb = 1'b0; swStbySel = 1'b0;
    chk("R3 modRst", 32'(modRst), 32'(ONES));
    chk("R3 counter reset", 32'(rfshCntRst), 32'd1);
    chk("R3 no full reset", 32'(rfshFullRst), 32'd0);
    rstN = 1'b0; step();
    chk("R8 reset from standby pin", 32'(clkPinMode), 32'(2'b00));
    chk("R8 reset from standby refresh", 32'(rfshFullRst), 32'd1);
    rstN = 1'b1; step();
    chk("R8 run", 32'(cpuClkEn), 32'd1);

    // R6 asynchronous entry from sleep
    modStbyWr = 1'b1; modStbyData = 6'b100000; step(); modStbyWr = 1'b0;
    sleepStb = 1'b1; step(); sleepStb = 1'b0;
    #3 stbyN = 1'b0;
    #1;
    chk("R6 async ports", 32'(portHiZ), 32'd1);
    chk("R6 async pin", 32'(clkPinMode), 32'(2'b10));
    chk("R6 async cpu", 32'(cpuClkEn), 32'd0);
    @(negedge clk);
    rstN = 1'b0; step();
    stbyN = 1'b1; step();
    chk("R7 exit to reset", 32'(portHiZ), 32'd0);
    chk("R7 held in reset", 32'(cpuClkEn), 32'd0);
    rstN = 1'b1; step();
    chk("R7 run", 32'(cpuClkEn), 32'd1);
    chk("R11 cleared by hw standby", 32'(modEn), 32'(ONES));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule